// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a two-wire serial slave that lets a host read and write a bank of 8-bit registers held outside the block. It samples SCL and SDA on the system clock through two-flop synchronizers and detects their edges there. It pulls SDA low through an open-drain output-enable pin and never drives the line high.

The 7-bit bus address has two parts. The upper three bits come from a parameter. The lower four bits come from strap pins. A write transaction first loads an internal register pointer and then stores data bytes at that pointer. A read transaction returns bytes starting at the current pointer. The pointer steps forward after every data byte, so bursts are possible, and it keeps its value between transactions. Because of this, a host can set the pointer with one write and read from there with a later or repeated-START read.

The register bank connects through a plain parallel port: address out, write data out, a single-cycle write strobe out, and read data in. The bank's read data is expected to follow the address combinationally. The address used for the alert-response call is never answered, whatever the parameter and straps are set to.

Top module: `i2c_reg_slave`

## Requirements
- R1: While reset is held and after it is released, sda_oe is 0 and reg_we is 0, so the bus stays released.
- R2: The first byte after START holds the 7-bit address in bits 7..1 and the direction in bit 0 (1 = read, 0 = write). When the address equals {FIXED_HI, strap}, the slave ACKs by pulling SDA low in the ninth clock.
- R3: When the address does not match, the slave NACKs and ignores every following byte until the next START or STOP. It writes nothing, leaves the pointer unchanged, and leaves SDA released, so a read shows 8'hFF.
- R4: In a write, the byte after the address loads the pointer. Each later byte is ACKed and stored through a one-cycle reg_we pulse, with reg_addr equal to the pointer and reg_wdata equal to the byte.
- R5: In a read, the slave shifts out reg_rdata at the current pointer, MSB first.
- R6: The pointer increments after each data byte written or read, wrapping at 8 bits. It keeps its value across transactions.
- R7: A master NACK ends a read. The slave releases SDA and waits for the next START.
- R8: A START at any point, including mid-byte, drops the partial byte without writing it and returns to address matching. This supports a repeated START from a write into a read.
- R9: A STOP at any point, including mid-byte, drops the partial byte, releases SDA and returns to idle.
- R10: The alert-response address 7'b0001100 is never ACKed, even when {FIXED_HI, strap} equals it.
- R11: sda_oe only becomes asserted while the synchronized SCL is low.
- R12: A change on the strap pins changes the answered address for the next transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| strap | input | 4 | Low four address bits |
| reg_addr | output | 8 | Register pointer toward the bank |
| reg_wdata | output | 8 | Byte to store |
| reg_we | output | 1 | One-cycle store strobe |
| reg_rdata | input | 8 | Byte at reg_addr from the bank |

## Verification
The bench aims at the points where a slave of this kind tends to slip:
- An address that differs only in one strap bit. A careless compare would ACK it.
- The alert-response address on a second instance strapped to exactly that value. A missing exclusion would ACK it.
- A STOP and a repeated START arriving after three or four data bits. A design that does not abort would store a half-shifted byte or lose address sync.
- A read that runs on from a pointer left behind by earlier transactions. An increment placed wrongly would return a neighbouring register.

It also confirms that SDA stays released after a master NACK, and that a read of a foreign address floats to 8'hFF.

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [2:0] FIXED_HI = 3'b001
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [3:0] strap,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);
  localparam logic [6:0] ALERT_ADDR = 7'b0001100;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_MACK} st_t;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} kind_t;

  logic [2:0] scl_q, sda_q;
  st_t        state;
  kind_t      kind;
  logic [3:0] cnt;
  logic [7:0] shreg, ptr;
  logic       rw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  wire scl_s    = scl_q[1];
  wire scl_d    = scl_q[2];
  wire sda_s    = sda_q[1];
  wire sda_d    = sda_q[2];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start    = scl_s & scl_d & sda_d & ~sda_s;
  wire stop     = scl_s & scl_d & ~sda_d & sda_s;
  wire hit      = (shreg[7:1] == {FIXED_HI, strap}) && (shreg[7:1] != ALERT_ADDR);

  assign reg_addr  = ptr;
  assign reg_wdata = shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      kind   <= K_ADDR;
      cnt    <= '0;
      shreg  <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      sda_oe <= 1'b0;
      reg_we <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (reg_we) ptr <= ptr + 8'd1;
      if (stop) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (start) begin
        state  <= S_RX;
        kind   <= K_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_RX: begin
            if (scl_rise && cnt != 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              case (kind)
                K_ADDR: begin
                  if (hit) begin
                    rw     <= shreg[0];
                    kind   <= K_PTR;
                    sda_oe <= 1'b1;
                    state  <= S_RACK;
                  end else begin
                    state <= S_IDLE;
                  end
                end
                K_PTR: begin
                  ptr    <= shreg;
                  kind   <= K_DATA;
                  sda_oe <= 1'b1;
                  state  <= S_RACK;
                end
                default: begin
                  reg_we <= 1'b1;
                  sda_oe <= 1'b1;
                  state  <= S_RACK;
                end
              endcase
            end
          end
          S_RACK: begin
            if (scl_fall) begin
              if (rw) begin
                shreg  <= reg_rdata;
                sda_oe <= ~reg_rdata[7];
                state  <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                cnt    <= '0;
                sda_oe <= 1'b0;
                ptr    <= ptr + 8'd1;
                state  <= S_MACK;
              end else begin
                cnt    <= cnt + 4'd1;
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
              end
            end
          end
          S_MACK: begin
            if (scl_rise && sda_s) begin
              state <= S_IDLE;
            end else if (scl_fall) begin
              shreg  <= reg_rdata;
              sda_oe <= ~reg_rdata[7];
              state  <= S_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (state == S_IDLE && !sda_oe));

  // R8
  start_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state == S_RX && cnt == 4'd0 && !sda_oe));

  // R4
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R3
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_oe);
endmodule

// File: tb/tb_i2c_reg_slave.sv
module tb_i2c_reg_slave;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic [3:0] strap = 4'b0101;
  logic       scl_line, sda_line, sda_oe, sda_oe2;
  logic [7:0] reg_addr, reg_wdata, reg_rdata, a2, w2;
  logic       reg_we, we2;
  logic [7:0] regs [256];
  logic [7:0] expv [256];
  logic [7:0] exp_ptr = 8'd0;
  int n_chk = 0, n_bad = 0, r11_bad = 0, we2_cnt = 0;

  assign scl_line  = ~m_scl_low;
  assign sda_line  = ~(m_sda_low | sda_oe | sda_oe2);
  assign reg_rdata = regs[reg_addr];

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 37 + 5);
  endfunction

  function automatic logic [6:0] my_addr();
    return {3'b001, strap};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) regs[i] <= init_val(i);
    end else if (reg_we) begin
      regs[reg_addr] <= reg_wdata;
    end
  end

  i2c_reg_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap(strap), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata)
  );

  i2c_reg_slave #(.FIXED_HI(3'b000)) dut_ara (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line), .sda_oe(sda_oe2),
    .strap(4'b1100), .reg_addr(a2), .reg_wdata(w2), .reg_we(we2),
    .reg_rdata(8'hA5)
  );

  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe && !prev_oe && scl_line) r11_bad++;
    if (rst_n && sda_oe2 && scl_line) r11_bad++;
    if (we2) we2_cnt++;
    prev_oe = sda_oe;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic start_c();
    m_sda_low = 1'b0; q();
    m_scl_low = 1'b0; q();
    m_sda_low = 1'b1; q();
    m_scl_low = 1'b1; q();
  endtask

  task automatic stop_c();
    m_sda_low = 1'b1; q();
    m_scl_low = 1'b0; q();
    m_sda_low = 1'b0; q();
  endtask

  task automatic wbit(input logic b);
    m_sda_low = !b; q();
    m_scl_low = 1'b0; q(); q();
    m_scl_low = 1'b1; q();
  endtask

  task automatic rbit(output logic b);
    m_sda_low = 1'b0; q();
    m_scl_low = 1'b0; q();
    b = sda_line; q();
    m_scl_low = 1'b1; q();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = !b;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic ack_it);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      d[i] = b;
    end
    wbit(!ack_it);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] p, input int n, input string tag);
    logic ack;
    logic [7:0] d;
    logic hit;
    hit = (a == my_addr());
    start_c();
    wbyte({a, 1'b0}, ack); check({tag, " address ack"}, ack, hit);
    wbyte(p, ack);         check({tag, " pointer ack"}, ack, hit);
    if (hit) exp_ptr = p;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      wbyte(d, ack); check({tag, " data ack"}, ack, hit);
      if (hit) begin
        expv[exp_ptr] = d;
        exp_ptr = exp_ptr + 8'd1;
      end
    end
    stop_c();
  endtask

  task automatic read_body(input int n, input string tag);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      rbyte(d, i != n - 1);
      check({tag, " read data"}, d, expv[exp_ptr]);
      exp_ptr = exp_ptr + 8'd1;
    end
    check({tag, " R7 SDA released after NACK"}, sda_line, 1'b1);
  endtask

  task automatic do_read(input logic [6:0] a, input int n, input string tag);
    logic ack;
    logic [7:0] d;
    logic hit;
    hit = (a == my_addr());
    start_c();
    wbyte({a, 1'b1}, ack); check({tag, " read address ack"}, ack, hit);
    if (hit) read_body(n, tag);
    else begin
      rbyte(d, 1'b0);
      check({tag, " R3 floating read"}, d, 8'hFF);
    end
    stop_c();
  endtask

  task automatic do_ptr_read(input logic [7:0] p, input int n, input string tag);
    logic ack;
    start_c();
    wbyte({my_addr(), 1'b0}, ack); check({tag, " R2 address ack"}, ack, 1'b1);
    wbyte(p, ack);                 check({tag, " R4 pointer ack"}, ack, 1'b1);
    exp_ptr = p;
    start_c();
    wbyte({my_addr(), 1'b1}, ack); check({tag, " R8 repeated start ack"}, ack, 1'b1);
    read_body(n, tag);
    stop_c();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL all: actual watchdog expiry expected completion");
    summary();
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) expv[i] = init_val(i);
    repeat (5) @(negedge clk);
    check("R1 sda_oe in reset", sda_oe, 1'b0);
    check("R1 reg_we in reset", reg_we, 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 sda_oe after reset", sda_oe, 1'b0);
    check("R1 SDA line after reset", sda_line, 1'b1);

    do_write(my_addr(), 8'h10, 3, "R4");
    do_ptr_read(8'h10, 3, "R5");

    do_write(my_addr(), 8'h20, 2, "R6");
    do_read(my_addr(), 2, "R6");
    do_ptr_read(8'h20, 2, "R6");

    do_write(my_addr() ^ 7'h01, 8'h30, 2, "R3");
    do_read(my_addr(), 1, "R3");
    do_read(my_addr() ^ 7'h08, 1, "R3");

    do_write(7'h0C, 8'h40, 1, "R10");
    do_read(7'h0C, 1, "R10");

    start_c();
    wbyte({my_addr(), 1'b0}, ack); check("R9 address ack", ack, 1'b1);
    wbyte(8'h50, ack);             check("R9 pointer ack", ack, 1'b1);
    exp_ptr = 8'h50;
    wbit(1'b0); wbit(1'b1); wbit(1'b0);
    stop_c();
    check("R9 SDA released after STOP", sda_line, 1'b1);
    do_read(my_addr(), 1, "R9");

    start_c();
    wbyte({my_addr(), 1'b0}, ack); check("R8 address ack", ack, 1'b1);
    wbyte(8'h60, ack);             check("R8 pointer ack", ack, 1'b1);
    exp_ptr = 8'h60;
    wbit(1'b1); wbit(1'b0); wbit(1'b1); wbit(1'b1);
    start_c();
    wbyte({my_addr(), 1'b1}, ack); check("R8 restart read ack", ack, 1'b1);
    rbyte(d, 1'b0);
    check("R8 unwritten register", d, expv[8'h60]);
    exp_ptr = exp_ptr + 8'd1;
    stop_c();

    strap = 4'b1010;
    q();
    do_write(7'b0010101, 8'h70, 1, "R12");
    do_write(my_addr(), 8'h70, 1, "R12");
    do_ptr_read(8'h70, 1, "R12");

    for (int it = 0; it < 24; it++) begin
      logic [6:0] a;
      int n, op;
      a  = ($urandom % 5 == 0) ? (my_addr() ^ 7'(1 + $urandom % 127)) : my_addr();
      n  = 1 + $urandom % 4;
      op = $urandom % 3;
      if (op == 0) do_write(a, 8'($urandom), n, "R4");
      else if (op == 1) do_read(a, n, "R6");
      else do_ptr_read(8'($urandom), n, "R5");
    end

    check("R11 SDA asserted only with SCL low", r11_bad, 0);
    check("R10 alert-address instance never stored", we2_cnt, 0);
    summary();
    $finish;
  end
endmodule